// File: doc/BRIEF.md
# CPU Clock Source Switch Sequencer

This controller owns the clock-source selection for one CPU cluster and carries out a rate change without leaving the cluster clock unsourced. A mux control register, reachable through a simple read/write port, holds a 2-bit primary select and a 2-bit secondary select. These fields drive the external clock muxes directly.

A rate change arrives as a request with a target frequency in kHz. Targets below 300 MHz are refused with a one-cycle error pulse. For an accepted target, the sequencer first parks the primary mux on the alternate PLL. It then emits a one-cycle reprogram strobe to the primary PLL, together with the frequency the PLL must lock at, and waits for lock. Once lock arrives, it selects the final path. Targets below 600 MHz run from the PLL divided by two through the secondary mux, so the PLL is locked at twice the target. Faster targets use the droop-detection path. If lock does not come within a programmable number of cycles, the sequencer flags an error and leaves the cluster on the alternate PLL.

Top module: `clksw_seq_top`

## Requirements
- R1: After reset the primary select is 3 (alternate PLL), the secondary select is 0 (crystal reference), and accept, reject, reprogram strobe and lock error are all low.
- R2: The mux register sits at byte address 0x40. Read data bits [1:0] hold the primary select and bits [3:2] hold the secondary select, with all other bits zero. Reads at any other address return zero, and writes to any other address change nothing.
- R3: A register write uses a 4-bit mask aligned with data bits [3:0]. Only the masked bits change, and every unmasked bit keeps its value.
- R4: A request with a target of at least 300000 kHz, made while the sequencer is idle, is accepted in the same cycle. The primary select then becomes 3, and only after that does the reprogram strobe pulse for exactly one cycle.
- R5: A request below 300000 kHz raises the reject output for one cycle and is not accepted. Both selects keep their values, and no reprogram strobe follows.
- R6: After lock, a target below 600000 kHz sets primary 0 (secondary path) and secondary 1 (PLL divided by two). A target of 600000 kHz or more sets primary 2 (droop-detection path) and leaves the secondary select unchanged.
- R7: The PLL target output is twice the requested rate for targets below 600000 kHz, and equal to the requested rate otherwise.
- R8: If lock does not arrive within timeout_i cycles after the strobe, the lock error output sets, the primary select stays 3, and the sequencer returns to idle. The next accepted request clears the lock error.
- R9: While a sequence is in progress, requests are not accepted and not rejected, and they leave the latched target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access valid |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 12 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_wmask_i | input | 4 | Bit mask for data bits [3:0] |
| reg_rdata_o | output | 32 | Read data |
| rate_req_i | input | 1 | Rate-change request |
| rate_khz_i | input | 32 | Target rate in kHz |
| rate_ack_o | output | 1 | Request accepted |
| rate_err_o | output | 1 | Request rejected |
| pll_lock_i | input | 1 | Primary PLL lock |
| timeout_i | input | 16 | Lock timeout in cycles |
| pll_prog_o | output | 1 | Reprogram strobe to the primary PLL |
| pll_khz_o | output | 32 | Frequency the PLL must lock at |
| lock_err_o | output | 1 | Lock timeout flag |
| pri_sel_o | output | 2 | Primary mux select |
| sec_sel_o | output | 2 | Secondary mux select |

## Verification
The properties assume that software does not write the mux register while a sequence runs, or in the cycle of a rejected request. Without that rule, the parked selection and the unchanged selection after a reject could not be relied on. The stimulus issues register writes only while the sequencer is idle and no rate request is pending. Lock is raised only after the strobe has been observed, and it is held low for the whole of the timeout case.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam logic [1:0] PRI_SUB   = 2'd0;
  localparam logic [1:0] PRI_PLL   = 2'd1;
  localparam logic [1:0] PRI_DROOP = 2'd2;
  localparam logic [1:0] PRI_ALT   = 2'd3;
  localparam logic [1:0] SEC_XO    = 2'd0;
  localparam logic [1:0] SEC_DIV2  = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PARK, ST_PROG, ST_WAIT, ST_RESEL, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/clksw_regs.sv
module clksw_regs
  import clksw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] MUX_ADDR = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_req_i,
  input  logic              sw_we_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic [DATA_W-1:0] sw_wdata_i,
  input  logic [3:0]        sw_wmask_i,
  output logic [DATA_W-1:0] sw_rdata_o,
  input  logic              hw_pri_we_i,
  input  logic [1:0]        hw_pri_i,
  input  logic              hw_sec_we_i,
  input  logic [1:0]        hw_sec_i,
  output logic [1:0]        pri_o,
  output logic [1:0]        sec_o
);
  logic       hit, sw_wr;
  logic [1:0] pri_q, sec_q, pri_sw, sec_sw;

  assign hit    = (sw_addr_i == MUX_ADDR);
  assign sw_wr  = sw_req_i && sw_we_i && hit;
  assign pri_sw = (pri_q & ~sw_wmask_i[1:0]) | (sw_wdata_i[1:0] & sw_wmask_i[1:0]);
  assign sec_sw = (sec_q & ~sw_wmask_i[3:2]) | (sw_wdata_i[3:2] & sw_wmask_i[3:2]);

  // sequencer updates win over software per field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= PRI_ALT;
      sec_q <= SEC_XO;
    end else begin
      if (hw_pri_we_i)  pri_q <= hw_pri_i;
      else if (sw_wr)   pri_q <= pri_sw;
      if (hw_sec_we_i)  sec_q <= hw_sec_i;
      else if (sw_wr)   sec_q <= sec_sw;
    end
  end

  assign sw_rdata_o = hit ? {{(DATA_W-4){1'b0}}, sec_q, pri_q} : '0;
  assign pri_o = pri_q;
  assign sec_o = sec_q;

  a_r3_unmasked_pri_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr && !hw_pri_we_i && sw_wmask_i[1:0] == 2'b00) |=> $stable(pri_q));
endmodule

// File: rtl/clksw_rate_dec.sv
module clksw_rate_dec #(
  parameter int RATE_W   = 32,
  parameter int MIN_KHZ  = 300000,
  parameter int DIV2_KHZ = 600000
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              reject_o,
  output logic              low_o,
  output logic [RATE_W-1:0] pll_khz_o
);
  localparam logic [RATE_W-1:0] MIN_L  = RATE_W'(MIN_KHZ);
  localparam logic [RATE_W-1:0] DIV2_L = RATE_W'(DIV2_KHZ);

  assign reject_o  = rate_i < MIN_L;
  assign low_o     = rate_i < DIV2_L;
  assign pll_khz_o = low_o ? {rate_i[RATE_W-2:0], 1'b0} : rate_i;
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int TO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              reject_i,
  input  logic              low_i,
  input  logic [RATE_W-1:0] pll_khz_i,
  input  logic              lock_i,
  input  logic [TO_W-1:0]   timeout_i,
  output logic              ack_o,
  output logic              err_o,
  output logic              prog_o,
  output logic [RATE_W-1:0] pll_khz_o,
  output logic              lock_err_o,
  output logic              hw_pri_we_o,
  output logic [1:0]        hw_pri_o,
  output logic              hw_sec_we_o,
  output logic [1:0]        hw_sec_o
);
  seq_state_e        state_q;
  logic [TO_W-1:0]   cnt_q;
  logic [TO_W:0]     cnt_nx;
  logic              low_q, lock_err_q;
  logic [RATE_W-1:0] pll_q;

  assign ack_o  = (state_q == ST_IDLE) && req_i && !reject_i;
  assign err_o  = (state_q == ST_IDLE) && req_i && reject_i;
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      low_q      <= 1'b0;
      pll_q      <= '0;
      lock_err_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ack_o) begin
          state_q    <= ST_PARK;
          low_q      <= low_i;
          pll_q      <= pll_khz_i;
          lock_err_q <= 1'b0;
        end
        ST_PARK: state_q <= ST_PROG;
        ST_PROG: begin
          state_q <= ST_WAIT;
          cnt_q   <= '0;
        end
        ST_WAIT: begin
          if (lock_i) state_q <= ST_RESEL;
          else if (cnt_nx >= {1'b0, timeout_i}) begin
            lock_err_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else cnt_q <= cnt_nx[TO_W-1:0];
        end
        ST_RESEL: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign prog_o      = (state_q == ST_PROG);
  assign hw_pri_we_o = (state_q == ST_PARK) || (state_q == ST_RESEL);
  assign hw_pri_o    = (state_q == ST_PARK) ? PRI_ALT : (low_q ? PRI_SUB : PRI_DROOP);
  assign hw_sec_we_o = (state_q == ST_RESEL) && low_q;
  assign hw_sec_o    = SEC_DIV2;
  assign pll_khz_o   = pll_q;
  assign lock_err_o  = lock_err_q;

  a_r4_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |=> !prog_o);
  a_r9_target_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(pll_khz_o));
endmodule

// File: rtl/clksw_seq_top.sv
module clksw_seq_top
  import clksw_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int RATE_W   = 32,
  parameter int TO_W     = 16,
  parameter int MIN_KHZ  = 300000,
  parameter int DIV2_KHZ = 600000,
  parameter logic [ADDR_W-1:0] MUX_ADDR = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [3:0]        reg_wmask_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              rate_req_i,
  input  logic [RATE_W-1:0] rate_khz_i,
  output logic              rate_ack_o,
  output logic              rate_err_o,
  input  logic              pll_lock_i,
  input  logic [TO_W-1:0]   timeout_i,
  output logic              pll_prog_o,
  output logic [RATE_W-1:0] pll_khz_o,
  output logic              lock_err_o,
  output logic [1:0]        pri_sel_o,
  output logic [1:0]        sec_sel_o
);
  logic              reject, low;
  logic [RATE_W-1:0] dec_khz;
  logic              pri_we, sec_we;
  logic [1:0]        pri_d, sec_d;

  clksw_rate_dec #(.RATE_W(RATE_W), .MIN_KHZ(MIN_KHZ), .DIV2_KHZ(DIV2_KHZ)) u_dec (
    .rate_i(rate_khz_i), .reject_o(reject), .low_o(low), .pll_khz_o(dec_khz));

  clksw_fsm #(.RATE_W(RATE_W), .TO_W(TO_W)) u_fsm (
    .clk_i, .rst_ni, .req_i(rate_req_i), .reject_i(reject), .low_i(low),
    .pll_khz_i(dec_khz), .lock_i(pll_lock_i), .timeout_i,
    .ack_o(rate_ack_o), .err_o(rate_err_o), .prog_o(pll_prog_o),
    .pll_khz_o, .lock_err_o,
    .hw_pri_we_o(pri_we), .hw_pri_o(pri_d), .hw_sec_we_o(sec_we), .hw_sec_o(sec_d));

  clksw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MUX_ADDR(MUX_ADDR)) u_regs (
    .clk_i, .rst_ni, .sw_req_i(reg_req_i), .sw_we_i(reg_we_i), .sw_addr_i(reg_addr_i),
    .sw_wdata_i(reg_wdata_i), .sw_wmask_i(reg_wmask_i), .sw_rdata_o(reg_rdata_o),
    .hw_pri_we_i(pri_we), .hw_pri_i(pri_d), .hw_sec_we_i(sec_we), .hw_sec_i(sec_d),
    .pri_o(pri_sel_o), .sec_o(sec_sel_o));

  a_r4_parked_at_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_prog_o |-> pri_sel_o == PRI_ALT);
  a_r5_reject_keeps_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_err_o && !(reg_req_i && reg_we_i)) |=> ($stable(pri_sel_o) && $stable(sec_sel_o)));
  a_r8_timeout_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_err_o) |-> pri_sel_o == PRI_ALT);
endmodule

// File: tb/clksw_seq_top_tb_top.sv
module clksw_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_wmask = '0;
  logic [31:0] reg_rdata;
  logic        rate_req = 1'b0;
  logic [31:0] rate_khz = '0;
  logic        rate_ack, rate_err;
  logic        pll_lock = 1'b0;
  logic [15:0] timeout = 16'd40;
  logic        pll_prog;
  logic [31:0] pll_khz;
  logic        lock_err;
  logic [1:0]  pri_sel, sec_sel;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  clksw_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(reg_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_wmask_i(reg_wmask),
    .reg_rdata_o(reg_rdata), .rate_req_i(rate_req), .rate_khz_i(rate_khz),
    .rate_ack_o(rate_ack), .rate_err_o(rate_err), .pll_lock_i(pll_lock),
    .timeout_i(timeout), .pll_prog_o(pll_prog), .pll_khz_o(pll_khz),
    .lock_err_o(lock_err), .pri_sel_o(pri_sel), .sec_sel_o(sec_sel));

  localparam int NV = 5;
  localparam logic [31:0] V_RATE [NV] = '{32'd600000, 32'd1500000, 32'd300000, 32'd599999, 32'd800000};
  localparam logic [1:0]  V_PRI  [NV] = '{2'd2, 2'd2, 2'd0, 2'd0, 2'd2};
  localparam logic [1:0]  V_SEC  [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd1};
  localparam logic [31:0] V_PLL  [NV] = '{32'd600000, 32'd1500000, 32'd600000, 32'd1199998, 32'd800000};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0; reg_addr = 12'h040;
  endtask

  task automatic reg_read(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, reg_rdata, exp);
    reg_addr = 12'h040;
  endtask

  // issue request, return ack; leaves bench one negedge after the accept edge
  task automatic send_req(input logic [31:0] r, output logic acked);
    @(negedge clk);
    rate_req = 1'b1; rate_khz = r;
    #1 acked = rate_ack;
    @(negedge clk);
    rate_req = 1'b0;
  endtask

  task automatic wait_prog(input string tag);
    bit seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      #1 if (pll_prog) seen = 1; else @(negedge clk);
    end
    check(tag, {31'd0, seen}, 32'd1);
    check("R4 parked on alternate at strobe", {30'd0, pri_sel}, 32'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic acked;
    reg_addr = 12'h040;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 primary reset", {30'd0, pri_sel}, 32'd3);
    check("R1 secondary reset", {30'd0, sec_sel}, 32'd0);
    check("R1 outputs idle", {28'd0, rate_ack, rate_err, pll_prog, lock_err}, 32'd0);
    reg_read("R2 readback after reset", 12'h040, 32'h3);

    // vector walk: accept, park, strobe, lock, reselect
    for (int v = 0; v < NV; v++) begin
      send_req(V_RATE[v], acked);
      check("R4 accepted", {31'd0, acked}, 32'd1);
      wait_prog("R4 strobe seen");
      check("R7 pll target", pll_khz, V_PLL[v]);
      @(negedge clk);
      check("R4 strobe one cycle", {31'd0, pll_prog}, 32'd0);
      pll_lock = 1'b1;
      repeat (5) @(negedge clk);
      pll_lock = 1'b0;
      #1;
      check("R6 primary final", {30'd0, pri_sel}, {30'd0, V_PRI[v]});
      check("R6 secondary final", {30'd0, sec_sel}, {30'd0, V_SEC[v]});
    end
    reg_read("R2 readback after sequence", 12'h040, 32'h6);

    // R9: request during sequence ignored
    send_req(32'd1000000, acked);
    wait_prog("R9 strobe seen");
    @(negedge clk);
    rate_req = 1'b1; rate_khz = 32'd700000;
    #1 check("R9 busy request not acked", {30'd0, rate_ack, rate_err}, 32'd0);
    @(negedge clk);
    rate_req = 1'b0;
    pll_lock = 1'b1;
    repeat (5) @(negedge clk);
    pll_lock = 1'b0;
    #1 check("R9 target kept", pll_khz, 32'd1000000);

    // R5: reject
    @(negedge clk);
    rate_req = 1'b1; rate_khz = 32'd299999;
    #1 check("R5 reject pulse", {30'd0, rate_ack, rate_err}, 32'd1);
    @(negedge clk);
    rate_req = 1'b0;
    #1 check("R5 reject one cycle", {31'd0, rate_err}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1 if (pll_prog) check("R5 no strobe after reject", 32'd1, 32'd0);
    end
    check("R5 selects unchanged", {28'd0, sec_sel, pri_sel}, 32'h6);

    // R3 masked writes
    reg_write(12'h040, 32'h1, 4'h3);
    reg_read("R3 primary written, secondary kept", 12'h040, 32'h5);
    reg_write(12'h040, 32'hF0, 4'hC);
    reg_read("R3 secondary written, primary kept", 12'h040, 32'h1);

    // R2 other address
    reg_write(12'h044, 32'hE, 4'hF);
    reg_read("R2 foreign write ignored", 12'h040, 32'h1);
    reg_read("R2 foreign read zero", 12'h044, 32'h0);

    // R8 timeout
    timeout = 16'd6;
    send_req(32'd900000, acked);
    wait_prog("R8 strobe seen");
    repeat (15) @(negedge clk);
    #1;
    check("R8 lock error set", {31'd0, lock_err}, 32'd1);
    check("R8 primary parked", {30'd0, pri_sel}, 32'd3);
    send_req(32'd450000, acked);
    check("R8 idle after timeout", {31'd0, acked}, 32'd1);
    #1 check("R8 error cleared on accept", {31'd0, lock_err}, 32'd0);
    wait_prog("R4 strobe after timeout");
    check("R7 doubled target", pll_khz, 32'd900000);
    pll_lock = 1'b1;
    repeat (5) @(negedge clk);
    pll_lock = 1'b0;
    #1 check("R6 low path after recovery", {28'd0, sec_sel, pri_sel}, 32'h4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule